// File: doc/BRIEF.md
# Comparator Event and Interrupt Control

This block is the digital shell around an on-chip analog comparator. It sees the comparator only as a single raw output bit, `cmp_raw`. It passes that bit through a two-flop synchronizer and watches the synchronized value for edges. Which edges count is chosen by a two-bit mode field. A matching edge sets a sticky interrupt flag. The block raises `irq` when three things are all one: that flag, a local enable bit and the global interrupt-enable input.

Software reaches the block through one 8-bit control/status register on a simple write-enable/read-data bus. Field positions:
- bit 7: comparator off.
- bit 6: internal-reference select.
- bit 5: synchronized comparator value, read-only.
- bit 4: event flag.
- bit 3: interrupt enable.
- bit 2: unused, reads as zero.
- bits 1:0: edge mode.

There are two ways to clear the flag. Software can write a one to bit 4, or the interrupt controller can pulse an acknowledge. The block also drives two steering outputs. One picks the internal reference or the pin for the positive input. The other hands the negative input to the converter multiplexer, but only while the converter is off.

Top module: `cmpctl_top`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00, `irq` is 0, `pos_sel_ref` is 0 and `cmp_power_off` is 0.
- R2: Bits 7, 6, 3 and 1:0 hold the value last written. Bit 2 always reads 0, and writing one to it changes nothing.
- R3: Read bit 5 equals `cmp_raw` delayed by two clock edges. Writes to bit 5 are ignored.
- R4: The edge mode in bits 1:0 selects which edges of the synchronized value set the flag one edge later:
  - 00: any change.
  - 01: no edge.
  - 10: 1-to-0.
  - 11: 0-to-1.
- R5: A register write with bit 4 set clears the flag. A write with bit 4 clear leaves the flag unchanged.
- R6: A one-cycle `irq_ack` pulse clears the flag.
- R7: When a flag-setting edge meets a write-one clear or an acknowledge in the same cycle, the flag ends up set.
- R8: `irq` is 1 exactly when the flag (bit 4), the enable (bit 3) and `gie` are all 1.
- R9: `pos_sel_ref` follows bit 6: 1 selects the internal reference, 0 selects the pin.
- R10: `neg_sel_mux` is 1 only when `mux_en` is 1 and `conv_en` is 0.
- R11: While bit 7 is 1:
  - `cmp_power_off` is 1.
  - The synchronizer holds its value.
  - No edge sets the flag.
  - After bit 7 is cleared, a value that changed while the comparator was off shows up as an ordinary edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| cmp_raw | input | 1 | Raw comparator output, asynchronous |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| gie | input | 1 | Global interrupt enable |
| conv_en | input | 1 | Converter enabled |
| mux_en | input | 1 | Request to route the converter multiplexer to the negative input |
| irq | output | 1 | Interrupt request |
| pos_sel_ref | output | 1 | Positive input selects the internal reference |
| neg_sel_mux | output | 1 | Negative input selects the converter multiplexer |
| cmp_power_off | output | 1 | Comparator power-down |

## Verification
The assertions take the following inputs as well-behaved:
- `irq_ack` arrives as a single-cycle pulse.
- A register write lasts exactly one cycle.
- `cmp_raw` is free to change at any time, because it only enters through the synchronizer.

The delay check waits until two cycles have passed since reset, and requires the comparator to have been on for both of those edges. The stimulus changes every input half a period away from the active edge. It holds `cmp_raw` steady long enough for each level to pass through both stages. It raises an acknowledge or a clear together with an edge only in the one deliberate collision case.

// File: rtl/cmpctl_pkg.sv
package cmpctl_pkg;
  localparam int REG_W   = 8;
  localparam int BIT_OFF = 7;
  localparam int BIT_REF = 6;
  localparam int BIT_SMP = 5;
  localparam int BIT_FLG = 4;
  localparam int BIT_IEN = 3;
  localparam int BIT_RSV = 2;
  localparam int MODE_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    EDGE_ANY  = 2'b00,
    EDGE_NONE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_RISE = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic       off;
    logic       ref_sel;
    logic       ien;
    edge_mode_e mode;
  } ctl_t;
endpackage

// File: rtl/cmpctl_sync.sv
module cmpctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_comb stg_d[i] = hold ? stg_q[i] : d;
      end else begin : g_rest
        always_comb stg_d[i] = hold ? stg_q[i] : stg_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cmpctl_edge.sv
module cmpctl_edge
  import cmpctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic       smp,
  input  edge_mode_e mode,
  output logic       hit
);
  logic prev_q;
  logic prev_d;
  logic rise;
  logic fall;

  always_comb begin
    prev_d = smp;
    rise   = smp & ~prev_q;
    fall   = ~smp & prev_q;
    unique case (mode)
      EDGE_ANY:  hit = rise | fall;
      EDGE_FALL: hit = fall;
      EDGE_RISE: hit = rise;
      default:   hit = 1'b0;
    endcase
    if (hold) hit = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/cmpctl_regs.sv
module cmpctl_regs
  import cmpctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             hit,
  input  logic             ack,
  output ctl_t             ctl,
  output logic             flag
);
  ctl_t ctl_q, ctl_d;
  logic flag_q, flag_d;

  always_comb begin
    ctl_d = ctl_q;
    if (we) begin
      ctl_d.off     = wdata[BIT_OFF];
      ctl_d.ref_sel = wdata[BIT_REF];
      ctl_d.ien     = wdata[BIT_IEN];
      ctl_d.mode    = edge_mode_e'(wdata[MODE_W-1:0]);
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (we && wdata[BIT_FLG]) flag_d = 1'b0;
    if (ack)                  flag_d = 1'b0;
    if (hit)                  flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      flag_q <= flag_d;
    end
  end

  assign ctl  = ctl_q;
  assign flag = flag_q;
endmodule

// File: rtl/cmpctl_top.sv
module cmpctl_top
  import cmpctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             cmp_raw,
  input  logic             irq_ack,
  input  logic             gie,
  input  logic             conv_en,
  input  logic             mux_en,
  output logic             irq,
  output logic             pos_sel_ref,
  output logic             neg_sel_mux,
  output logic             cmp_power_off
);
  ctl_t ctl;
  logic flag;
  logic smp;
  logic cmp_event;

  cmpctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (ctl.off),
    .d     (cmp_raw),
    .q     (smp)
  );

  cmpctl_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (ctl.off),
    .smp   (smp),
    .mode  (ctl.mode),
    .hit   (cmp_event)
  );

  cmpctl_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .wdata (reg_wdata),
    .hit   (cmp_event),
    .ack   (irq_ack),
    .ctl   (ctl),
    .flag  (flag)
  );

  always_comb begin
    reg_rdata                 = '0;
    reg_rdata[BIT_OFF]        = ctl.off;
    reg_rdata[BIT_REF]        = ctl.ref_sel;
    reg_rdata[BIT_SMP]        = smp;
    reg_rdata[BIT_FLG]        = flag;
    reg_rdata[BIT_IEN]        = ctl.ien;
    reg_rdata[BIT_RSV]        = 1'b0;
    reg_rdata[MODE_W-1:0]     = ctl.mode;
  end

  assign irq           = flag & ctl.ien & gie;
  assign pos_sel_ref   = ctl.ref_sel;
  assign neg_sel_mux   = mux_en & ~conv_en;
  assign cmp_power_off = ctl.off;
endmodule

// File: rtl/cmpctl_chk.sv
module cmpctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       cmp_raw,
  input logic       irq_ack,
  input logic       gie,
  input logic       conv_en,
  input logic       irq,
  input logic       neg_sel_mux,
  input logic       cmp_event
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[2] == 1'b0);

  p_sync_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && !$past(reg_rdata[7], 1) && !$past(reg_rdata[7], 2))
      |-> reg_rdata[5] == $past(cmp_raw, 2));

  p_wr1_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_wdata[4] && !cmp_event) |=> !reg_rdata[4]);

  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !cmp_event) |=> !reg_rdata[4]);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_event |=> reg_rdata[4]);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (reg_rdata[4] && reg_rdata[3] && gie));

  p_neg_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_en |-> !neg_sel_mux);

  p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7] |-> !cmp_event);

  p_off_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && $past(reg_rdata[7])) |-> $stable(reg_rdata[5]));
endmodule

bind cmpctl_top cmpctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we      (reg_we),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .cmp_raw     (cmp_raw),
  .irq_ack     (irq_ack),
  .gie         (gie),
  .conv_en     (conv_en),
  .irq         (irq),
  .neg_sel_mux (neg_sel_mux),
  .cmp_event   (cmp_event)
);

// File: tb/cmpctl_top_test.sv
module cmpctl_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 25;

  logic       clk;
  logic       rst_n;
  logic       reg_we;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       cmp_raw;
  logic       irq_ack;
  logic       gie;
  logic       conv_en;
  logic       mux_en;
  logic       irq;
  logic       pos_sel_ref;
  logic       neg_sel_mux;
  logic       cmp_power_off;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // {we, wdata, raw, ack, gie, expected rdata, expected irq}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b1, 8'h0B, 1'b0, 1'b0, 1'b1, 8'h0B, 1'b0},  // R2 rise mode, enable
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h0B, 1'b0},  // R3 first stage only
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h2B, 1'b0},  // R3 second stage
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h3B, 1'b1},  // R4 rise sets flag
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h3B, 1'b0},  // R8 gie low
    {1'b1, 8'h0B, 1'b1, 1'b0, 1'b1, 8'h3B, 1'b1},  // R5 write zero keeps flag
    {1'b1, 8'h1B, 1'b1, 1'b0, 1'b1, 8'h2B, 1'b0},  // R5 write one clears
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h2B, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h0B, 1'b0},  // R4 fall ignored in rise
    {1'b1, 8'h0A, 1'b0, 1'b0, 1'b1, 8'h0A, 1'b0},  // fall mode
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h0A, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h2A, 1'b0},  // R4 rise ignored in fall
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h2A, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h0A, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h1A, 1'b1},  // R4 fall sets flag
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h0A, 1'b0},  // R6 ack clears
    {1'b1, 8'h08, 1'b0, 1'b0, 1'b1, 8'h08, 1'b0},  // toggle mode
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h08, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h28, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h38, 1'b1},  // R4 toggle sets flag
    {1'b1, 8'h3C, 1'b1, 1'b0, 1'b1, 8'h28, 1'b0},  // R2 bit2, R3 bit5 ignored
    {1'b1, 8'h09, 1'b1, 1'b0, 1'b1, 8'h29, 1'b0},  // reserved mode 01
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h29, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h09, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h09, 1'b0}   // R4 mode 01 no flag
  };

  cmpctl_top uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_we        (reg_we),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .cmp_raw       (cmp_raw),
    .irq_ack       (irq_ack),
    .gie           (gie),
    .conv_en       (conv_en),
    .mux_en        (mux_en),
    .irq           (irq),
    .pos_sel_ref   (pos_sel_ref),
    .neg_sel_mux   (neg_sel_mux),
    .cmp_power_off (cmp_power_off)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic we, input logic [7:0] wd, input logic raw,
                     input logic ack, input logic g);
    reg_we    = we;
    reg_wdata = wd;
    cmp_raw   = raw;
    irq_ack   = ack;
    gie       = g;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_wdata = 8'h00; cmp_raw = 1'b0;
    irq_ack = 1'b0; gie = 1'b1; conv_en = 1'b0; mux_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 ref", {7'd0, pos_sel_ref}, 8'h00);
    check("R1 off", {7'd0, cmp_power_off}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      logic [20:0] v;
      v = VEC[i];
      cyc(v[20], v[19:12], v[11], v[10], v[9]);
      check($sformatf("R4 vec%0d rdata", i), reg_rdata, v[8:1]);
      check($sformatf("R8 vec%0d irq", i), {7'd0, irq}, {7'd0, v[0]});
    end

    // R7 set meets both clears in the same cycle
    cyc(1'b1, 8'h08, 1'b1, 1'b0, 1'b1);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
    cyc(1'b1, 8'h18, 1'b1, 1'b1, 1'b1);
    check("R7 set wins", reg_rdata, 8'h38);
    check("R7 irq", {7'd0, irq}, 8'h01);
    cyc(1'b0, 8'h00, 1'b1, 1'b1, 1'b1);
    check("R6 ack after collision", reg_rdata, 8'h28);

    // R9 and R10 steering
    cyc(1'b1, 8'h48, 1'b1, 1'b0, 1'b1);
    check("R9 ref on", {7'd0, pos_sel_ref}, 8'h01);
    mux_en = 1'b1; conv_en = 1'b0; #1;
    check("R10 mux routed", {7'd0, neg_sel_mux}, 8'h01);
    conv_en = 1'b1; #1;
    check("R10 converter on", {7'd0, neg_sel_mux}, 8'h00);
    mux_en = 1'b0; conv_en = 1'b0; #1;
    check("R10 mux off", {7'd0, neg_sel_mux}, 8'h00);
    cyc(1'b1, 8'h08, 1'b1, 1'b0, 1'b1);
    check("R9 ref off", {7'd0, pos_sel_ref}, 8'h00);

    // R11 comparator off freezes sampling
    cyc(1'b1, 8'h88, 1'b1, 1'b0, 1'b1);
    check("R11 power off", {7'd0, cmp_power_off}, 8'h01);
    repeat (4) cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    check("R11 held while off", reg_rdata, 8'hA8);
    check("R11 no irq while off", {7'd0, irq}, 8'h00);
    cyc(1'b1, 8'h08, 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    check("R11 stale edge after enable", reg_rdata, 8'h08);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    check("R11 spurious flag", reg_rdata, 8'h18);
    check("R11 spurious irq", {7'd0, irq}, 8'h01);

    done = 1;
    summary();
    $finish;
  end
endmodule